// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer

This block sequences the low-power state of a synchronous memory. A sleep request comes in asynchronously, high to sleep and low for normal work. It is first passed through a short flop chain. A four-state machine then runs the entry phase and the exit phase, each for a fixed number of clocks. From the start of entry until the end of exit, the block tells the access logic to stop starting accesses and to hold the data pins at high impedance. On the first entry clock it also raises a one-cycle abort, so that an access still in flight is dropped and not completed. The array contents are assumed to be kept. Power gating appears only as a status output.

The states are AWAKE, ENTERING, ASLEEP and EXITING. These are the transitions:
- AWAKE to ENTERING: the synchronised request is high.
- ENTERING to ASLEEP: the entry count has run out. This happens even if the request dropped in the meantime.
- ASLEEP to EXITING: the synchronised request is low.
- EXITING to AWAKE: the exit count has run out.

A recovery window opens on the return to AWAKE. While it is open, every chip enable and address strobe must stay inactive. A sticky violation flag catches two misuses: activity on any of those inputs inside the window, and a request that is recognised while the device is still selected. Only reset clears the flag.

Top module: `sleep_ctl`

## Requirements
- R1: After reset the state is AWAKE and all six outputs are low: access_block, dq_hiz, entry_abort, power_down, recovering, violation.
- R2: Suppose sleep_req is raised before clock edge k. Then access_block and dq_hiz first read high after edge k+SYNC_STAGES, which is k+2 by default, and they are low before that edge.
- R3: ENTERING lasts ENTRY_CYCLES clocks (default 2). power_down rises exactly ENTRY_CYCLES edges after access_block rises.
- R4: entry_abort is high for exactly one cycle, the first ENTERING cycle, and never at any other time.
- R5: While the request stays high, the state stays in ASLEEP. In ASLEEP, power_down, access_block and dq_hiz are all high.
- R6: Suppose the request drops before edge k while the block is asleep. Then power_down falls after edge k+SYNC_STAGES. access_block and dq_hiz stay high for EXIT_CYCLES further clocks (default 2) and then fall.
- R7: When access_block falls at the end of exit, recovering goes high for exactly RECOVERY_CYCLES clocks (default 2).
- R8: Any active chip enable or strobe sampled while recovering is high sets violation. The active levels are en_a_n low, en_b high, en_c_n low, strobe_p_n low and strobe_c_n low.
- R9: If dev_selected is high on the edge where AWAKE sees the synchronised request, violation is set. If dev_selected is low, the flag is unaffected.
- R10: violation stays high once set, until reset.
- R11: A request pulse that drops during ENTERING still completes entry into ASLEEP, and the block then goes straight into EXITING.
- R12: Chip-enable and strobe activity outside the recovery window has no effect on violation. This covers activity while asleep and activity after the window has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| dev_selected | input | 1 | Device currently selected or access in progress |
| en_a_n | input | 1 | Chip enable A, active low |
| en_b | input | 1 | Chip enable B, active high |
| en_c_n | input | 1 | Chip enable C, active low |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| access_block | output | 1 | New accesses blocked (every state but AWAKE) |
| dq_hiz | output | 1 | Force data outputs to high impedance |
| entry_abort | output | 1 | One-cycle abort of an in-flight access |
| power_down | output | 1 | Power-gated status (ASLEEP) |
| recovering | output | 1 | Post-exit recovery window open |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest case to reach from the ports is a single enable or strobe pulse placed on each individual cycle at the edge of the recovery window. The window is closed by a count that only starts after two synchroniser stages and the whole exit phase. The stimulus walks each of the five inputs across offsets zero to RECOVERY_CYCLES after the exit. Each run starts from reset, so the sticky flag reports exactly one offset, and the expected result is violation set only when the offset is below the window length. A second hard case is the short request pulse that vanishes during entry. It is driven for a single clock, and the bench checks that the block lands in ASLEEP and then exits without any further stimulus.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE    = 2'd0,
        ST_ENTERING = 2'd1,
        ST_ASLEEP   = 2'd2,
        ST_EXITING  = 2'd3
    } slp_state_t;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b0;
                end else if (i == 0) begin
                    chain_q[i] <= async_in;
                end else begin
                    chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/slp_downcnt.sv
module slp_downcnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
    import sleep_ctl_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int ENTRY_CYCLES    = 2,
    parameter int EXIT_CYCLES     = 2,
    parameter int RECOVERY_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic dev_selected,
    input  logic en_a_n,
    input  logic en_b,
    input  logic en_c_n,
    input  logic strobe_p_n,
    input  logic strobe_c_n,
    output logic access_block,
    output logic dq_hiz,
    output logic entry_abort,
    output logic power_down,
    output logic recovering,
    output logic violation
);
    localparam int MAX_PHASE = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
    localparam int PW        = $clog2(MAX_PHASE + 1);
    localparam int RW        = $clog2(RECOVERY_CYCLES + 1);
    localparam logic [PW-1:0] ENTRY_LAST = PW'(ENTRY_CYCLES - 1);
    localparam logic [PW-1:0] EXIT_LAST  = PW'(EXIT_CYCLES - 1);
    localparam logic [RW-1:0] REC_LOAD   = RW'(RECOVERY_CYCLES);

    slp_state_t    state_q, state_d;
    logic          req_s;
    logic          phase_load;
    logic [PW-1:0] phase_val;
    logic [PW-1:0] phase_cnt;
    logic          rec_load;
    logic [RW-1:0] rec_val;
    logic [RW-1:0] rec_cnt;
    logic          bus_activity;
    logic          viol_q;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    slp_downcnt #(.W(PW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .count    (phase_cnt)
    );

    slp_downcnt #(.W(RW)) u_recov (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rec_load),
        .load_val (rec_val),
        .count    (rec_cnt)
    );

    assign bus_activity = !en_a_n | en_b | !en_c_n | !strobe_p_n | !strobe_c_n;

    // next-state and counter control
    always_comb begin
        state_d    = state_q;
        phase_load = 1'b0;
        phase_val  = '0;
        rec_load   = 1'b0;
        rec_val    = '0;
        unique case (state_q)
            ST_AWAKE: begin
                if (req_s) begin
                    state_d    = ST_ENTERING;
                    phase_load = 1'b1;
                    phase_val  = ENTRY_LAST;
                    rec_load   = 1'b1;
                    rec_val    = '0;
                end
            end
            ST_ENTERING: begin
                if (phase_cnt == '0) begin
                    state_d = ST_ASLEEP;
                end
            end
            ST_ASLEEP: begin
                if (!req_s) begin
                    state_d    = ST_EXITING;
                    phase_load = 1'b1;
                    phase_val  = EXIT_LAST;
                end
            end
            ST_EXITING: begin
                if (phase_cnt == '0) begin
                    state_d  = ST_AWAKE;
                    rec_load = 1'b1;
                    rec_val  = REC_LOAD;
                end
            end
            default: state_d = ST_AWAKE;
        endcase
    end

    // state and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_AWAKE && req_s && dev_selected) ||
                (rec_cnt != '0 && bus_activity)) begin
                viol_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        access_block = (state_q != ST_AWAKE);
        dq_hiz       = (state_q != ST_AWAKE);
        entry_abort  = (state_q == ST_ENTERING) && (phase_cnt == ENTRY_LAST);
        power_down   = (state_q == ST_ASLEEP);
        recovering   = (rec_cnt != '0);
        violation    = viol_q;
    end
endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic access_block,
    input logic dq_hiz,
    input logic entry_abort,
    input logic power_down,
    input logic recovering,
    input logic violation
);
    // R5
    asleep_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> (access_block && dq_hiz));

    // R4
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_abort |=> !entry_abort);

    // R4
    abort_in_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_abort |-> (access_block && !power_down));

    // R3
    abort_on_block_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_block) |-> entry_abort);

    // R6
    exit_still_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_down) |-> access_block);

    // R7
    recovery_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recovering |-> !access_block);

    // R7
    recovery_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(access_block) |-> recovering);

    // R10
    violation_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
endmodule

bind sleep_ctl sleep_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .access_block (access_block),
    .dq_hiz       (dq_hiz),
    .entry_abort  (entry_abort),
    .power_down   (power_down),
    .recovering   (recovering),
    .violation    (violation)
);

// File: tb/sleep_ctl_tb.sv
module sleep_ctl_tb;
    localparam int SY = 2;
    localparam int EN = 2;
    localparam int EX = 2;
    localparam int RC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic dev_selected = 1'b0;
    logic en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1, strobe_p_n = 1'b1, strobe_c_n = 1'b1;
    logic access_block, dq_hiz, entry_abort, power_down, recovering, violation;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sleep_ctl #(
        .SYNC_STAGES(SY), .ENTRY_CYCLES(EN), .EXIT_CYCLES(EX), .RECOVERY_CYCLES(RC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .dev_selected(dev_selected),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
        .access_block(access_block), .dq_hiz(dq_hiz), .entry_abort(entry_abort),
        .power_down(power_down), .recovering(recovering), .violation(violation)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic set_act(input int sel, input logic on);
        case (sel)
            0: en_a_n     = !on;
            1: en_b       = on;
            2: en_c_n     = !on;
            3: strobe_p_n = !on;
            4: strobe_c_n = !on;
            default: ;
        endcase
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sleep_req = 1'b0;
        dev_selected = 1'b0;
        for (int s = 0; s < 5; s++) set_act(s, 1'b0);
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    // raise request and follow entry edge by edge
    task automatic do_enter();
        sleep_req = 1'b1;
        for (int t = 1; t <= SY + 1 + EN; t++) begin
            tick();
            check("R2 block", access_block, t >= SY + 1);
            check("R2 hiz", dq_hiz, t >= SY + 1);
            check("R4 abort", entry_abort, t == SY + 1);
            check("R3 pd", power_down, t == SY + 1 + EN);
        end
    endtask

    // stay asleep for hold cycles, with bus noise applied (R12)
    task automatic do_hold(input int hold);
        for (int t = 0; t < hold; t++) begin
            set_act(t % 5, 1'b1);
            tick();
            set_act(t % 5, 1'b0);
            check("R5 pd", power_down, 1'b1);
            check("R5 block", access_block, 1'b1);
            check("R12 asleep noise", violation, 1'b0);
        end
    endtask

    // drop request; optional activity pulse at recovery offset j
    task automatic do_exit(input int sel, input int j);
        sleep_req = 1'b0;
        for (int t = 1; t <= SY + EX + RC + 3; t++) begin
            tick();
            set_act(sel, 1'b0);
            check("R6 pd", power_down, t <= SY);
            check("R6 block", access_block, t <= SY + EX);
            check("R7 recovering", recovering, (t > SY + EX) && (t <= SY + EX + RC));
            if (sel >= 0 && t == SY + EX + 1 + j) set_act(sel, 1'b1);
        end
    endtask

    initial begin
        do_reset();
        check("R1 block", access_block, 1'b0);
        check("R1 hiz", dq_hiz, 1'b0);
        check("R1 abort", entry_abort, 1'b0);
        check("R1 pd", power_down, 1'b0);
        check("R1 recovering", recovering, 1'b0);
        check("R1 violation", violation, 1'b0);

        // clean cycles with several sleep lengths
        for (int h = 0; h < 4; h++) begin
            do_enter();
            do_hold(h * 3);
            do_exit(-1, 0);
            check("R12 clean cycle", violation, 1'b0);
        end
        // activity after the window is harmless
        for (int s = 0; s < 5; s++) begin
            set_act(s, 1'b1);
            tick();
            set_act(s, 1'b0);
            tick();
            check("R12 after window", violation, 1'b0);
        end

        // sweep every enable/strobe over recovery offsets
        for (int s = 0; s < 5; s++) begin
            for (int j = 0; j <= RC; j++) begin
                do_reset();
                do_enter();
                do_exit(s, j);
                tick();
                check("R8 window activity", violation, j < RC);
                for (int k = 0; k < 3; k++) tick();
                check("R10 sticky", violation, j < RC);
                do_reset();
                check("R10 reset clears", violation, 1'b0);
            end
        end

        // request while selected
        for (int sel = 0; sel < 2; sel++) begin
            do_reset();
            dev_selected = sel[0];
            sleep_req = 1'b1;
            for (int t = 1; t <= SY + 1; t++) begin
                tick();
                check("R9 selected", violation, (t == SY + 1) && sel == 1);
            end
            dev_selected = 1'b0;
            tick();
            check("R9 sticky", violation, sel == 1);
        end

        // one-clock request pulse
        do_reset();
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        for (int t = 2; t <= SY + EN + EX + 4; t++) begin
            tick();
            check("R11 block", access_block, (t >= SY + 1) && (t <= SY + EN + 1 + EX));
            check("R11 pd", power_down, t == SY + 1 + EN);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule